// File: doc/BRIEF.md
# Bitfield Clear and Insert Unit

This unit is a single-stage datapath that changes one contiguous field of a destination word. It offers two operations. The clear operation forces the field to zero. The insert operation fills the field with the low-order bits of a source word. The field is given by a start position and a length. Every destination bit outside the field keeps its value. The unit computes no status flags.

A request is presented with a valid strobe. On the next rising clock edge the unit registers three outputs: the merged word, a write-enable for the destination, and a flag that reports bad field parameters. A condition-pass bit comes from outside the unit. When that bit is low the destination must not be written. The field mask is built by one of two interchangeable variants, chosen by a parameter. One variant uses a shifter. The other uses one comparator pair per bit.

Top module: `bitfield_unit`

## Requirements
- R1: A clear (`op_sel` = 0) with a legal field sets to zero exactly `field_len` bits of `dst_val`, starting at bit `field_lsb`.
- R2: An insert (`op_sel` = 1) with a legal field replaces bits `field_lsb` to `field_lsb+field_len-1` of `dst_val` with `src_val[field_len-1:0]`.
- R3: For both operations, every bit of `out_data` outside the selected field equals the same bit of `dst_val`.
- R4: The field `field_lsb` = 0, `field_len` = 32 is legal and covers the whole word: a clear gives 0 and an insert gives `src_val`.
- R5: A field is illegal when `field_len` is 0 or when `field_lsb + field_len` exceeds 32. For an illegal field, `out_illegal` is 1, `out_wen` is 0 and `out_data` equals `dst_val`, whatever the values of `cond_pass` and `op_sel`.
- R6: When `cond_pass` is 0 on a valid request, `out_wen` is 0 and `out_data` equals `dst_val`. `out_illegal` still reports the legality of the field.
- R7: During a clear, `src_val` has no effect on `out_data`.
- R8: The outputs update on the rising edge that samples `in_valid` = 1. After an edge with `in_valid` = 0, `out_wen` and `out_illegal` are 0 and `out_data` keeps its previous value.
- R9: A synchronous active-high `rst` sets `out_data` to 0 and sets `out_wen` and `out_illegal` to 0.
- R10: A valid request with a legal field and `cond_pass` = 1 gives `out_wen` = 1 and `out_illegal` = 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| cond_pass | input | 1 | External condition result; 0 blocks the write |
| op_sel | input | 1 | 0 = clear, 1 = insert |
| field_lsb | input | 5 | Lowest bit position of the field |
| field_len | input | 6 | Number of bits in the field |
| dst_val | input | 32 | Destination operand |
| src_val | input | 32 | Source operand for insert |
| out_data | output | 32 | Registered merged word |
| out_wen | output | 1 | Registered destination write-enable |
| out_illegal | output | 1 | Registered illegal-field flag |

## Verification
The bench sweeps every legal pair of start position and length for both operations and checks each field edge. A mask that is off by one at either edge would change a neighbouring bit or leave a field bit unchanged. The full-word field is tested on its own, because a mask built by a plain 32-bit shift of one would wrap to zero, so the unit would not write the word. The bench also tests zero length and fields one bit past the top of the word, with the condition bit both high and low. A design that checked only the length, or that let the condition bit hide the flag, would report the wrong legality. A clear is run with several different source words, and an idle cycle follows a write. These tests catch a design that lets the source leak into a clear or that keeps write-enable high after an idle cycle.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   typedef enum logic {
      BFU_OP_CLEAR  = 1'b0,
      BFU_OP_INSERT = 1'b1
   } bfu_op_e;

   localparam int BFU_MASK_SHIFT   = 0;
   localparam int BFU_MASK_COMPARE = 1;

endpackage

// File: rtl/bfu_range_check.sv
module bfu_range_check #(
   parameter int DATA_W = 32,
   parameter int POS_W  = $clog2(DATA_W),
   parameter int LEN_W  = POS_W + 1
) (
   input  logic [POS_W-1:0] start_pos,
   input  logic [LEN_W-1:0] span,
   output logic             in_range
);
   localparam int SUM_W = LEN_W + 1;
   localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DATA_W);

   logic [SUM_W-1:0] end_excl;

   always_comb begin
      end_excl = SUM_W'(start_pos) + SUM_W'(span);
      in_range = (span != '0) && (end_excl <= LIMIT);
   end
endmodule

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen
   import bfu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int POS_W      = $clog2(DATA_W),
   parameter int LEN_W      = POS_W + 1,
   parameter int MASK_STYLE = BFU_MASK_SHIFT
) (
   input  logic [POS_W-1:0]  start_pos,
   input  logic [LEN_W-1:0]  span,
   output logic [DATA_W-1:0] mask
);
   localparam int SUM_W = LEN_W + 1;

   generate
      if (MASK_STYLE == BFU_MASK_SHIFT) begin : g_shift
         // A shift count at or above the word width yields zero, so the
         // full-width span inverts to all ones with no wrap.
         logic [DATA_W-1:0] low_ones;
         always_comb begin
            low_ones = ~({DATA_W{1'b1}} << span);
            mask     = low_ones << start_pos;
         end
      end else begin : g_compare
         logic [SUM_W-1:0] lo_bound;
         logic [SUM_W-1:0] hi_bound;
         always_comb begin
            lo_bound = SUM_W'(start_pos);
            hi_bound = SUM_W'(start_pos) + SUM_W'(span);
         end
         for (genvar b = 0; b < DATA_W; b++) begin : g_bit
            localparam logic [SUM_W-1:0] IDX = SUM_W'(b);
            assign mask[b] = (IDX >= lo_bound) && (IDX < hi_bound);
         end
      end
   endgenerate
endmodule

// File: rtl/bfu_field_merge.sv
module bfu_field_merge
   import bfu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int POS_W  = $clog2(DATA_W)
) (
   input  bfu_op_e           op,
   input  logic [POS_W-1:0]  start_pos,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] dst,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] merged
);
   logic [DATA_W-1:0] aligned;
   logic [DATA_W-1:0] fill;

   always_comb begin
      aligned = src << start_pos;
      fill    = (op == BFU_OP_INSERT) ? (aligned & mask) : '0;
      merged  = (dst & ~mask) | fill;
   end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
   import bfu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int POS_W      = $clog2(DATA_W),
   parameter int LEN_W      = POS_W + 1,
   parameter int MASK_STYLE = BFU_MASK_SHIFT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              cond_pass,
   input  logic              op_sel,
   input  logic [POS_W-1:0]  field_lsb,
   input  logic [LEN_W-1:0]  field_len,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] src_val,
   output logic [DATA_W-1:0] out_data,
   output logic              out_wen,
   output logic              out_illegal
);
   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("bitfield_unit: DATA_W must be a power of two");
      end
      if (POS_W != $clog2(DATA_W) || LEN_W != POS_W + 1) begin : g_bad_idx
         $error("bitfield_unit: POS_W/LEN_W inconsistent with DATA_W");
      end
      if (MASK_STYLE != BFU_MASK_SHIFT && MASK_STYLE != BFU_MASK_COMPARE) begin : g_bad_style
         $error("bitfield_unit: unknown MASK_STYLE");
      end
   endgenerate

   bfu_op_e           op;
   logic              legal;
   logic              commit;
   logic [DATA_W-1:0] field_mask;
   logic [DATA_W-1:0] merged;

   assign op = bfu_op_e'(op_sel);

   bfu_range_check #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_range (
      .start_pos (field_lsb),
      .span      (field_len),
      .in_range  (legal)
   );

   bfu_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W),
                  .MASK_STYLE(MASK_STYLE)) u_mask (
      .start_pos (field_lsb),
      .span      (field_len),
      .mask      (field_mask)
   );

   bfu_field_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
      .op        (op),
      .start_pos (field_lsb),
      .mask      (field_mask),
      .dst       (dst_val),
      .src       (src_val),
      .merged    (merged)
   );

   assign commit = legal && cond_pass;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_data    <= '0;
         out_wen     <= 1'b0;
         out_illegal <= 1'b0;
      end else if (in_valid) begin
         out_data    <= commit ? merged : dst_val;
         out_wen     <= commit;
         out_illegal <= !legal;
      end else begin
         out_wen     <= 1'b0;
         out_illegal <= 1'b0;
      end
   end

   AST_MASK_WIDTH: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legal) |-> ($countones(field_mask) == int'(field_len))); // R1

   AST_OUTSIDE_KEPT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && legal) |=> ((out_data & ~$past(field_mask)) == ($past(dst_val) & ~$past(field_mask)))); // R3

   AST_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cond_pass && field_lsb == '0 && field_len == LEN_W'(DATA_W)) |=> (out_wen && !out_illegal)); // R4

   AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && field_len == '0) |=> (out_illegal && !out_wen && out_data == $past(dst_val))); // R5

   AST_COND_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !cond_pass) |=> (!out_wen && out_data == $past(dst_val))); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_wen && !out_illegal && $stable(out_data))); // R8
endmodule

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        cond_pass;
   logic        op_sel;
   logic [4:0]  field_lsb;
   logic [5:0]  field_len;
   logic [31:0] dst_val;
   logic [31:0] src_val;
   logic [31:0] out_data;
   logic        out_wen;
   logic        out_illegal;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bitfield_unit i_bitfield_unit (
      .clk, .rst, .in_valid, .cond_pass, .op_sel, .field_lsb, .field_len,
      .dst_val, .src_val, .out_data, .out_wen, .out_illegal
   );

   function automatic bit ref_legal(int lsb, int len);
      return (len != 0) && (lsb + len <= 32);
   endfunction

   function automatic logic [31:0] ref_data(bit op, logic [31:0] d, logic [31:0] s,
                                            int lsb, int len, bit cnd);
      logic [31:0] r = d;
      if (ref_legal(lsb, len) && cnd) begin
         for (int i = 0; i < 32; i++) begin
            if (i >= lsb && i < lsb + len) r[i] = op ? s[i - lsb] : 1'b0;
         end
      end
      return r;
   endfunction

   task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
      end
   endtask

   // Drives one request, waits for the capturing edge and checks all outputs.
   task automatic run_op(string req, bit op, logic [31:0] d, logic [31:0] s,
                         int lsb, int len, bit cnd);
      bit lg = ref_legal(lsb, len);
      @(negedge clk);
      in_valid  = 1'b1;
      cond_pass = cnd;
      op_sel    = op;
      field_lsb = 5'(lsb);
      field_len = 6'(len);
      dst_val   = d;
      src_val   = s;
      @(posedge clk);
      #1;
      check(req, "data",    out_data, ref_data(op, d, s, lsb, len, cnd));
      check(req, "wen",     {31'b0, out_wen},     {31'b0, lg && cnd});
      check(req, "illegal", {31'b0, out_illegal}, {31'b0, !lg});
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk); #1;
      check("R9", "data",    out_data, 32'h0);
      check("R9", "wen",     {31'b0, out_wen}, 32'h0);
      check("R9", "illegal", {31'b0, out_illegal}, 32'h0);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic t_examples();
      run_op("R1", 1'b0, 32'hFFFF_FFFF, 32'h0, 8, 12, 1'b1);
      check("R1", "clear 8..19", out_data, 32'hFFF0_00FF);
      run_op("R2", 1'b1, 32'h1234_5678, 32'hFFFF_FABC, 8, 12, 1'b1);
      check("R2", "insert 8..19", out_data, 32'h123A_BC78);
      run_op("R10", 1'b1, 32'h0, 32'h1, 31, 1, 1'b1);
      check("R10", "top bit", out_data, 32'h8000_0000);
   endtask

   task automatic t_full_word();
      run_op("R4", 1'b0, 32'hDEAD_BEEF, 32'h1111_1111, 0, 32, 1'b1);
      check("R4", "full clear", out_data, 32'h0);
      run_op("R4", 1'b1, 32'hDEAD_BEEF, 32'hCAFE_F00D, 0, 32, 1'b1);
      check("R4", "full insert", out_data, 32'hCAFE_F00D);
   endtask

   task automatic t_illegal();
      run_op("R5", 1'b1, 32'h0BAD_F00D, 32'hFFFF_FFFF, 4, 0, 1'b1);
      run_op("R5", 1'b0, 32'h0BAD_F00D, 32'hFFFF_FFFF, 1, 32, 1'b1);
      run_op("R5", 1'b1, 32'h0BAD_F00D, 32'hFFFF_FFFF, 31, 2, 1'b1);
      run_op("R5", 1'b1, 32'h0BAD_F00D, 32'hFFFF_FFFF, 20, 63, 1'b0);
      run_op("R5", 1'b0, 32'h0BAD_F00D, 32'h0, 0, 33, 1'b1);
   endtask

   task automatic t_cond_fail();
      run_op("R6", 1'b1, 32'h5555_AAAA, 32'hFFFF_FFFF, 0, 16, 1'b0);
      run_op("R6", 1'b0, 32'h5555_AAAA, 32'h0, 0, 32, 1'b0);
   endtask

   task automatic t_src_ignored();
      run_op("R7", 1'b0, 32'h89AB_CDEF, 32'h0000_0000, 5, 9, 1'b1);
      run_op("R7", 1'b0, 32'h89AB_CDEF, 32'hFFFF_FFFF, 5, 9, 1'b1);
      run_op("R7", 1'b0, 32'h89AB_CDEF, 32'h1357_9BDF, 5, 9, 1'b1);
   endtask

   task automatic t_idle_hold();
      logic [31:0] held;
      run_op("R8", 1'b1, 32'h0, 32'hFFFF_FFFF, 3, 4, 1'b1);
      held = out_data;
      @(negedge clk);
      in_valid = 1'b0;
      dst_val  = 32'h7777_7777;
      @(posedge clk); #1;
      check("R8", "idle wen",     {31'b0, out_wen}, 32'h0);
      check("R8", "idle data",    out_data, held);
      run_op("R8", 1'b1, 32'h0, 32'h0, 40 % 32, 0, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      @(posedge clk); #1;
      check("R8", "idle illegal", {31'b0, out_illegal}, 32'h0);
   endtask

   task automatic t_sweep();
      for (int lsb = 0; lsb < 32; lsb++) begin
         for (int len = 1; len <= 32 - lsb; len++) begin
            logic [31:0] d = 32'hA5C3_0F96 ^ (32'(lsb) * 32'h0101_0101);
            logic [31:0] s = 32'h6E2D_B417 + (32'(len) * 32'h0011_3355);
            run_op("R2", 1'b1, d, s, lsb, len, 1'b1);
            run_op("R1", 1'b0, ~d, s, lsb, len, 1'b1);
         end
      end
      run_op("R3", 1'b1, 32'hFFFF_FFFF, 32'h0, 13, 7, 1'b1);
      check("R3", "edges", out_data, 32'hFFF0_1FFF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; cond_pass = 1'b0; op_sel = 1'b0;
      field_lsb = '0; field_len = '0; dst_val = '0; src_val = '0;
      repeat (2) @(posedge clk);
      t_reset();
      t_examples();
      t_full_word();
      t_illegal();
      t_cond_fail();
      t_src_ignored();
      t_idle_hold();
      t_sweep();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule